// File: doc/BRIEF.md
# Interleaved Three-Level Sequence Detector

This block turns a stream of three-level soft symbols into hard bits. It uses maximum-likelihood sequence detection in place of fixed slicing. Each sample arrives as a signed word with a valid strobe. Samples are dealt alternately to two identical detector lanes: even-indexed samples go to lane 0 and odd-indexed samples to lane 1, so each lane steps at half the symbol rate. Each lane runs a four-state trellis. Within a lane, the ideal level of a symbol is the lane's current bit minus the lane bit two lane-steps earlier, taken as 0 before the first bit. Across the whole stream, the level of symbol k is d[k] − d[k−4], with d of a negative index equal to 0.

Each lane holds four path metrics and a 32-deep register-exchange survivor memory. A two-bit field selects how deep into that memory the decision is read. The two lanes emit their decisions in the original bit order. When detection is switched off, each sample is sliced on its magnitude, so a nonzero level gives a 1. The block sits after the post-detection filter and works on symbols that have already been timed.

Top module: `tri_level_mlsd`

## Requirements
- R1: While rst_n is low at a rising edge, bit_valid is low after that edge. After reset, all path metrics, survivors and fill counters are zero, and the sample index restarts at 0.
- R2: With mlsd_en = 0, every sample gives bit_valid exactly one cycle later. bit_data is 1 when |smp_data| ≥ LEVEL/2 and 0 otherwise.
- R3: With mlsd_en = 1, samples with even index since reset go to lane 0 and odd ones to lane 1. The output bits come out in the original sample order.
- R4: Each lane decodes the trellis with states (d[k−1], d[k−2]). The branch from a state for input bit u has ideal level u − d[k−2], taken from the set {−1, 0, +1} and scaled by LEVEL.
- R5: The branch metric is |sample − ideal| saturated to 8 bits. Path metrics are 10 bits, saturate, and have the smallest metric subtracted on every step. Ties in the add-compare-select and in the choice of best state go to the lower index. Full-scale input must still decode correctly.
- R6: depth_sel picks the depth D: 0 gives 4, 1 gives 6, 2 gives 8, 3 gives 32. The bit for sample k is emitted together with the response to sample k + 2D.
- R7: In detection mode, no bit is emitted for the first 2D samples after reset.
- R8: After the fill, exactly one bit comes out one cycle after each valid sample. Cycles with smp_valid low change nothing, whatever smp_data holds.
- R9: A noiseless or lightly noisy stream (|noise| ≤ 20 at LEVEL = 64) decodes without error. This holds when the first four bits are 1, and it holds through long runs of zeros afterwards.
- R10: A reset in the middle of a stream restarts the fill. The first bit emitted after the reset is bit 0 of the new stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Soft sample strobe |
| smp_data | input | SMP_W (8) | Signed soft sample |
| mlsd_en | input | 1 | 1: sequence detection, 0: magnitude slicer |
| depth_sel | input | 2 | Decision depth select |
| bit_valid | output | 1 | Decided bit strobe |
| bit_data | output | 1 | Decided bit |

## Verification
The assertions assume that mlsd_en and depth_sel stay fixed from the release of reset until the next reset. The fill and steady-state checks count samples from reset under that assumption. The bench changes these inputs only while rst_n is low. The assertions on bypass data assume that LEVEL lies well above zero in magnitude. The bench's stimulus keeps each residue class of the sample index mod 4 starting with a nonzero level, so the starting state of every sub-chain is resolved. It also keeps noise below half the level spacing.

// File: rtl/tlm_pkg.sv
// Shared constants and the depth decode for the three-level sequence detector.
// Assumes: the survivor memory of every lane is at least DEPTH_MAX deep.
package tlm_pkg;
    localparam int DEPTH_MAX = 32;
    localparam int N_STATES  = 4;
    localparam int N_LEVELS  = 3;

    // Map the two-bit depth select to a decision depth in lane steps.
    function automatic int unsigned depth_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4;
            2'd1:    return 6;
            2'd2:    return 8;
            default: return 32;
        endcase
    endfunction
endpackage

// File: rtl/tlm_branch_metric.sv
// Distance of one soft sample to each of the three ideal levels
// (-LEVEL, 0, +LEVEL), saturated to BM_W bits.
// Assumes: SMP_W + 3 > BM_W and |LEVEL| fits in SMP_W + 1 bits.
module tlm_branch_metric #(
    parameter int SMP_W = 8,
    parameter int BM_W  = 8,
    parameter int LEVEL = 64
) (
    input  logic signed [SMP_W-1:0]              smp,
    output logic [tlm_pkg::N_LEVELS-1:0][BM_W-1:0] bm
);
    localparam int EW = SMP_W + 3;
    localparam logic [EW-1:0] BM_MAX = EW'((1 << BM_W) - 1);

    logic signed [EW-1:0] xe;

    // Sign-extend the sample so the subtraction cannot wrap.
    assign xe = {{3{smp[SMP_W-1]}}, smp};

    for (genvar g = 0; g < tlm_pkg::N_LEVELS; g++) begin : g_lvl
        localparam logic signed [EW-1:0] REF = EW'((g - 1) * LEVEL);
        logic signed [EW-1:0] diff;
        logic [EW-1:0]        mag;

        // Absolute distance to this level, clipped to the metric width.
        always_comb begin
            diff = xe - REF;
            mag  = diff[EW-1] ? EW'(-diff) : EW'(diff);
            bm[g] = (mag > BM_MAX) ? '1 : mag[BM_W-1:0];
        end
    end
endmodule

// File: rtl/tlm_slicer.sv
// Plain magnitude slicer used when sequence detection is off:
// a sample at or above half the level in magnitude gives a 1.
// Assumes: one decision per valid sample, registered once.
module tlm_slicer #(
    parameter int SMP_W = 8,
    parameter int LEVEL = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic signed [SMP_W-1:0] smp,
    output logic                    dec_valid,
    output logic                    dec_bit
);
    localparam int            EW   = SMP_W + 1;
    localparam logic [EW-1:0] HALF = EW'(LEVEL / 2);

    logic signed [EW-1:0] xe;
    logic [EW-1:0]        mag;

    // Magnitude of the sample in one extra bit.
    always_comb begin
        xe  = {smp[SMP_W-1], smp};
        mag = xe[EW-1] ? EW'(-xe) : EW'(xe);
    end

    // Register the threshold decision on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_bit   <= 1'b0;
        end else begin
            dec_valid <= step;
            if (step) begin
                dec_bit <= (mag >= HALF);
            end
        end
    end
endmodule

// File: rtl/tlm_lane.sv
// One four-state detector lane: branch metrics, add-compare-select,
// metric normalisation and a register-exchange survivor memory.
// State index = {d[k-1], d[k-2]}; the branch for bit u has level u - d[k-2].
// Assumes: depth_sel stays fixed between resets; SURV_D >= DEPTH_MAX.
module tlm_lane #(
    parameter int SMP_W  = 8,
    parameter int BM_W   = 8,
    parameter int PM_W   = 10,
    parameter int LEVEL  = 64,
    parameter int SURV_D = tlm_pkg::DEPTH_MAX
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic signed [SMP_W-1:0] smp,
    input  logic [1:0]              depth_sel,
    output logic                    dec_valid,
    output logic                    dec_bit
);
    localparam int NS = tlm_pkg::N_STATES;
    localparam int CW = $clog2(SURV_D + 2);
    localparam logic [CW-1:0] STEP_MAX = CW'(SURV_D + 1);

    logic [tlm_pkg::N_LEVELS-1:0][BM_W-1:0] bm;
    logic [PM_W-1:0]   pm_q   [NS];
    logic [PM_W-1:0]   pm_raw [NS];
    logic [PM_W-1:0]   pm_d   [NS];
    logic [SURV_D-1:0] surv_q [NS];
    logic [SURV_D:0]   path   [NS];
    logic [PM_W-1:0]   pm_min;
    logic [1:0]        best;
    logic [CW-1:0]     steps_q;
    logic [CW-1:0]     tap;

    assign tap = CW'(tlm_pkg::depth_of(depth_sel));

    tlm_branch_metric #(
        .SMP_W(SMP_W),
        .BM_W (BM_W),
        .LEVEL(LEVEL)
    ) bmu_i (
        .smp(smp),
        .bm (bm)
    );

    for (genvar ns = 0; ns < NS; ns++) begin : g_acs
        localparam int U  = ns / 2;
        localparam int A  = ns % 2;
        localparam int P0 = A * 2;
        localparam int P1 = A * 2 + 1;
        logic [PM_W:0] cand0;
        logic [PM_W:0] cand1;
        logic [PM_W:0] win;
        logic          pick1;

        // Add-compare-select into state ns; equal candidates keep the lower predecessor.
        always_comb begin
            cand0 = {1'b0, pm_q[P0]} + (PM_W + 1)'(bm[U + 1]);
            cand1 = {1'b0, pm_q[P1]} + (PM_W + 1)'(bm[U]);
            pick1 = (cand1 < cand0);
            win   = pick1 ? cand1 : cand0;
            pm_raw[ns] = win[PM_W] ? '1 : win[PM_W-1:0];
            path[ns]   = pick1 ? {surv_q[P1], 1'(U)} : {surv_q[P0], 1'(U)};
        end
    end

    // Find the smallest new metric; strict compare keeps the lowest index on ties.
    always_comb begin
        pm_min = pm_raw[0];
        best   = 2'd0;
        for (int i = 1; i < NS; i++) begin
            if (pm_raw[i] < pm_min) begin
                pm_min = pm_raw[i];
                best   = 2'(i);
            end
        end
    end

    // Normalise all metrics against the smallest one.
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            pm_d[i] = pm_raw[i] - pm_min;
        end
    end

    // Advance the trellis and emit the decision at the selected depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                pm_q[i]   <= '0;
                surv_q[i] <= '0;
            end
            steps_q   <= '0;
            dec_valid <= 1'b0;
            dec_bit   <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            if (step) begin
                for (int i = 0; i < NS; i++) begin
                    pm_q[i]   <= pm_d[i];
                    surv_q[i] <= path[i][SURV_D-1:0];
                end
                if (steps_q != STEP_MAX) begin
                    steps_q <= steps_q + 1'b1;
                end
                dec_valid <= (steps_q >= tap);
                dec_bit   <= path[best][tap];
            end
        end
    end
endmodule

// File: rtl/tri_level_mlsd.sv
// Top of the interleaved three-level sequence detector. Deals samples
// alternately to two lanes, or to a magnitude slicer when detection is
// off, and merges the registered decisions back into one bit stream.
// Assumes: mlsd_en and depth_sel change only while rst_n is low.
module tri_level_mlsd #(
    parameter int SMP_W  = 8,
    parameter int BM_W   = 8,
    parameter int PM_W   = 10,
    parameter int LEVEL  = 64,
    parameter int SURV_D = tlm_pkg::DEPTH_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             mlsd_en,
    input  logic [1:0]       depth_sel,
    output logic             bit_valid,
    output logic             bit_data
);
    localparam int N_LANES = 2;

    logic               phase_q;
    logic [N_LANES-1:0] lane_v;
    logic [N_LANES-1:0] lane_b;
    logic               sl_v;
    logic               sl_b;

    // Track which lane takes the next sample in detection mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (smp_valid && mlsd_en) begin
            phase_q <= ~phase_q;
        end
    end

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        logic take;

        // A lane steps only on its own half of the samples.
        assign take = smp_valid && mlsd_en && (phase_q == 1'(l));

        tlm_lane #(
            .SMP_W (SMP_W),
            .BM_W  (BM_W),
            .PM_W  (PM_W),
            .LEVEL (LEVEL),
            .SURV_D(SURV_D)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (take),
            .smp      (smp_data),
            .depth_sel(depth_sel),
            .dec_valid(lane_v[l]),
            .dec_bit  (lane_b[l])
        );
    end

    tlm_slicer #(
        .SMP_W(SMP_W),
        .LEVEL(LEVEL)
    ) slicer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (smp_valid && !mlsd_en),
        .smp      (smp_data),
        .dec_valid(sl_v),
        .dec_bit  (sl_b)
    );

    // Merge: at most one source holds a valid decision in any cycle.
    always_comb begin
        bit_valid = (|lane_v) || sl_v;
        if (lane_v[0]) begin
            bit_data = lane_b[0];
        end else if (lane_v[1]) begin
            bit_data = lane_b[1];
        end else begin
            bit_data = sl_b;
        end
    end
endmodule

// File: rtl/tri_level_mlsd_chk.sv
// Port-level properties of the three-level sequence detector.
// Assumes: mode inputs are fixed between resets.
module tri_level_mlsd_chk #(
    parameter int SMP_W = 8,
    parameter int LEVEL = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [SMP_W-1:0] smp_data,
    input logic             mlsd_en,
    input logic [1:0]       depth_sel,
    input logic             bit_valid,
    input logic             bit_data
);
    logic [7:0] seen_q;
    logic [7:0] fill;

    assign fill = 8'(2 * tlm_pkg::depth_of(depth_sel));

    // Count accepted samples since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (smp_valid && seen_q != 8'hFF) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !bit_valid);

    assert_bit_needs_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(smp_valid));

    assert_bypass_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mlsd_en && smp_valid) |=> bit_valid);

    assert_bypass_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mlsd_en && smp_valid && smp_data == '0) |=> (bit_valid && !bit_data));

    assert_bypass_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mlsd_en && smp_valid && smp_data == SMP_W'(LEVEL)) |=> (bit_valid && bit_data));

    assert_fill_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mlsd_en && bit_valid) |-> (seen_q > fill));

    assert_steady_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mlsd_en && smp_valid && seen_q >= fill && seen_q != 8'hFF) |=> bit_valid);
endmodule

bind tri_level_mlsd tri_level_mlsd_chk #(
    .SMP_W(SMP_W),
    .LEVEL(LEVEL)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_data (smp_data),
    .mlsd_en  (mlsd_en),
    .depth_sel(depth_sel),
    .bit_valid(bit_valid),
    .bit_data (bit_data)
);

// File: tb/tri_level_mlsd_tb_top.sv
// Bench: a table of stream configurations walked by one loop, then directed
// checks for reset, bypass latency and a mid-stream reset.
module tri_level_mlsd_tb_top;
    localparam int  CLK_NS = 20;
    localparam int  LVL    = 64;
    localparam int  MAXN   = 256;
    localparam int  N_ROWS = 8;
    // Row: {kind[1:0], en, sel[1:0], n[7:0], seed[7:0]}
    // kind 0 noisy, 1 noisy with idle gaps, 2 full-scale, 3 sparse ones
    localparam logic [20:0] ROWS [N_ROWS] = '{
        {2'd0, 1'b1, 2'd0, 8'd80,  8'h5A},
        {2'd0, 1'b1, 2'd1, 8'd80,  8'h3C},
        {2'd1, 1'b1, 2'd2, 8'd90,  8'hA7},
        {2'd0, 1'b1, 2'd3, 8'd160, 8'h1F},
        {2'd0, 1'b0, 2'd0, 8'd60,  8'h77},
        {2'd2, 1'b1, 2'd1, 8'd70,  8'hC3},
        {2'd3, 1'b1, 2'd3, 8'd150, 8'hE1},
        {2'd1, 1'b0, 2'd2, 8'd50,  8'h29}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = '0;
    logic       mlsd_en = 1'b0;
    logic [1:0] depth_sel = '0;
    logic       bit_valid;
    logic       bit_data;

    int n_chk = 0;
    int n_bad = 0;
    int bits [MAXN];
    int samp [MAXN];
    int cap  [MAXN];
    int cap_n = 0;

    always #(CLK_NS / 2) clk = ~clk;

    tri_level_mlsd dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .mlsd_en  (mlsd_en),
        .depth_sel(depth_sel),
        .bit_valid(bit_valid),
        .bit_data (bit_data)
    );

    // Capture decided bits away from the active edge.
    always @(negedge clk) begin
        if (rst_n && bit_valid && cap_n < MAXN) begin
            cap[cap_n] = bit_data ? 1 : 0;
            cap_n = cap_n + 1;
        end
    end

    function automatic int depth_for(input logic [1:0] s);
        case (s)
            2'd0:    return 4;
            2'd1:    return 6;
            2'd2:    return 8;
            default: return 32;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic en, input logic [1:0] sel);
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        mlsd_en = en;
        depth_sel = sel;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cap_n = 0;
    endtask

    // Build the bit stream and its three-level samples for one row.
    task automatic build(input int kind, input int n, input int seed);
        logic [7:0] lf = 8'(seed) | 8'h01;
        for (int k = 0; k < n; k++) begin
            int lvl, amp, nz, s;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            if (k < 4)          bits[k] = 1;
            else if (kind == 3) bits[k] = (k % 11 == 0) ? 1 : 0;
            else                bits[k] = lf[0] ? 1 : 0;
            lvl = bits[k] - ((k >= 4) ? bits[k-4] : 0);
            amp = (kind == 2) ? 127 : LVL;
            nz  = (kind == 2) ? 0 : (((k * 37 + seed) % 41) - 20);
            s   = lvl * amp + nz;
            if (s > 127)  s = 127;
            if (s < -128) s = -128;
            samp[k] = s;
        end
    endtask

    task automatic run_row(input logic [20:0] row);
        int kind = int'(row[20:19]);
        logic en = row[18];
        logic [1:0] sel = row[17:16];
        int n = int'(row[15:8]);
        int seed = int'(row[7:0]);
        int d2 = 2 * depth_for(sel);
        int exp_n = en ? (n - d2) : n;
        int first_bad = -1;
        int act_b = 0;
        int exp_b = 0;
        build(kind, n, seed);
        do_reset(en, sel);
        for (int k = 0; k < n; k++) begin
            smp_valid = 1'b1;
            smp_data = 8'(samp[k]);
            @(negedge clk);
            if (kind == 1 && k % 3 == 2) begin
                smp_valid = 1'b0;
                smp_data = 8'h55;
                @(negedge clk);
            end
        end
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R6 R7 R8 R10: count = n - 2D in detection mode, n in bypass
        check(cap_n == exp_n, en ? "R6/R7/R8" : "R2", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            int e;
            if (en) e = bits[i];
            else    e = (samp[i] >= LVL / 2 || samp[i] <= -(LVL / 2)) ? 1 : 0;
            if (cap[i] != e && first_bad < 0) begin
                first_bad = i;
                act_b = cap[i];
                exp_b = e;
            end
        end
        // R3 R4 R5 R9: decoded bits in original order (R2 in bypass)
        check(first_bad < 0, en ? "R3/R4/R5/R9" : "R2", act_b, exp_b);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(1'b1, 2'd0);
        check(bit_valid == 1'b0, "R1", int'(bit_valid), 0);

        for (int r = 0; r < N_ROWS; r++) begin
            run_row(ROWS[r]);
        end

        // R2: bypass gives its bit exactly one cycle after the sample
        do_reset(1'b0, 2'd0);
        smp_valid = 1'b1;
        smp_data = 8'(LVL);
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data = 8'h00;
        check(bit_valid && bit_data, "R2", int'({bit_valid, bit_data}), 3);
        @(negedge clk);
        check(!bit_valid, "R2", int'(bit_valid), 0);

        // R1 R10: reset in mid-stream silences output, then restarts the fill
        build(0, 40, 8'h6B);
        do_reset(1'b1, 2'd0);
        for (int k = 0; k < 30; k++) begin
            smp_valid = 1'b1;
            smp_data = 8'(samp[k]);
            @(negedge clk);
        end
        check(bit_valid, "R8", int'(bit_valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!bit_valid, "R1", int'(bit_valid), 0);
        rst_n = 1'b1;
        cap_n = 0;
        for (int k = 0; k < 12; k++) begin
            smp_valid = 1'b1;
            smp_data = 8'(samp[k]);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(cap_n == 4, "R10", cap_n, 4);
        check(cap_n > 0 && cap[0] == bits[0], "R10", cap[0], bits[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule